// File: doc/BRIEF.md
# Reversible-Gate Wallace Tree Multiplier

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product without any clock. Every logic element is a reversible gate cell: partial products come from three-input controlled-AND cells whose target line is held at 0. Operand bits are copied through chains of controlled-NOT cells, so every gate output drives exactly one load. Carry-save compression uses four-line sum/carry cells, and a two-line-plus-target cell serves as the half adder at the low end of the final adder.

The partial-product rows are compressed in groups of three. Each group of three rows becomes one sum row and one carry row shifted left by one place, and rows left over in a group pass through unchanged. Layers repeat until two rows remain: for 8 operand bits the row count goes 8, 6, 4, 3, 2. A ripple adder built from the same cells then sums the last two rows. Constant inputs are tied low, and the garbage outputs of each cell are left unloaded.

Top module: `rev_wallace_mul`

## Requirements
- R1: For every pair of operands, `prod` equals the unsigned product `a*b`, with all 16 bits kept.
- R2: When either operand is 0, `prod` is 0.
- R3: When one operand is 1, `prod` equals the other operand, zero-extended to 16 bits.
- R4: The largest operands, 255 times 255, give 65025 (0xFE01), with bit 15 set.
- R5: The block has no storage: `prod` follows a change on `a` or `b` without any clock edge in between.
- R6: Multiplying by a power of two, 2^k, gives the other operand shifted left by k places.
- R7: Swapping the operands does not change the product.
- R8: Bit 0 of `prod` equals `a[0] AND b[0]`, so an odd times an odd operand gives an odd product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Multiplicand, unsigned |
| b | input | 8 | Multiplier, unsigned |
| prod | output | 16 | Unsigned product of a and b |

## Verification
Zero and unit operands show whether the controlled-AND array gates rows and columns as it should. Single-bit operands send one row through the tree unchanged, so a wrong column weight shows up as a misplaced bit. The all-ones, alternating-bit and nibble-mask patterns fill every column and drive the longest carry paths through the compression layers and the final ripple adder. Swapped operand pairs separate a fault in the multiplicand copy chains from one in the multiplier copy chains, and a few thousand random pairs cover the rest of the space.

// File: rtl/rev_wallace_mul.sv
module rev_wallace_mul #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] prod
);
  localparam int W = 2 * N;

  function automatic int next_rows(input int r);
    return 2 * (r / 3) + r % 3;
  endfunction

  function automatic int rows_at(input int n, input int l);
    int r = n;
    for (int i = 0; i < l; i++) r = next_rows(r);
    return r;
  endfunction

  function automatic int depth(input int n);
    int r = n;
    int d = 0;
    while (r > 2) begin
      r = next_rows(r);
      d++;
    end
    return d;
  endfunction

  localparam int LV = depth(N);

  function automatic logic [1:0] feynman(input logic x, input logic y);
    return {x, x ^ y};
  endfunction

  function automatic logic [2:0] toffoli(input logic x, input logic y, input logic z);
    return {x, y, (x & y) ^ z};
  endfunction

  function automatic logic [2:0] peres(input logic x, input logic y, input logic z);
    return {x, x ^ y, (x & y) ^ z};
  endfunction

  function automatic logic [3:0] tsg(input logic x, input logic y, input logic z, input logic w);
    return {x, x ^ y, x ^ y ^ w, ((x ^ y) & w) ^ (x & y) ^ z};
  endfunction

  logic [N-1:0] a_chain [N];
  logic [N-1:0] a_copy  [N];
  logic [N-1:0] b_chain [N];
  logic [N-1:0] b_copy  [N];

  for (genvar i = 0; i < N; i++) begin : g_fan
    assign a_chain[i][0] = a[i];
    assign b_chain[i][0] = b[i];
    for (genvar k = 0; k < N - 1; k++) begin : g_cp
      assign {a_chain[i][k+1], a_copy[i][k]} = feynman(a_chain[i][k], 1'b0);
      assign {b_chain[i][k+1], b_copy[i][k]} = feynman(b_chain[i][k], 1'b0);
    end
    assign a_copy[i][N-1] = a_chain[i][N-1];
    assign b_copy[i][N-1] = b_chain[i][N-1];
  end

  for (genvar l = 0; l <= LV; l++) begin : lay
    localparam int RC = rows_at(N, l);
    logic [W-1:0] r [RC];

    if (l == 0) begin : g_pp
      for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar k = 0; k < W; k++) begin : g_col
          if (k >= j && k < j + N) begin : g_and
            logic unused_p, unused_q;
            assign {unused_p, unused_q, r[j][k]} = toffoli(a_copy[k-j][j], b_copy[j][k-j], 1'b0);
          end else begin : g_zero
            assign r[j][k] = 1'b0;
          end
        end
      end
    end else begin : g_red
      localparam int PR = rows_at(N, l - 1);
      localparam int G  = PR / 3;
      for (genvar g = 0; g < G; g++) begin : g_grp
        assign r[2*g+1][0] = 1'b0;
        for (genvar k = 0; k < W; k++) begin : g_col
          logic unused_p, unused_q, s, c;
          assign {unused_p, unused_q, s, c} =
            tsg(lay[l-1].r[3*g][k], lay[l-1].r[3*g+1][k], 1'b0, lay[l-1].r[3*g+2][k]);
          assign r[2*g][k] = s;
          if (k < W - 1) begin : g_keep
            assign r[2*g+1][k+1] = c;
          end else begin : g_drop
            logic unused_c;
            assign unused_c = c;
          end
        end
      end
      for (genvar t = 0; t < PR % 3; t++) begin : g_pass
        assign r[2*G+t] = lay[l-1].r[3*G+t];
      end
    end
  end

  logic [W-1:0] row_s;
  logic [W-1:0] row_c;
  logic [W-1:0] cy;

  assign row_s = lay[LV].r[0];
  assign row_c = lay[LV].r[1];

  logic unused_h;
  assign {unused_h, prod[0], cy[1]} = peres(row_s[0], row_c[0], 1'b0);
  assign cy[0] = 1'b0;

  for (genvar k = 1; k < W; k++) begin : g_rip
    logic unused_p, unused_q, c;
    assign {unused_p, unused_q, prod[k], c} = tsg(row_s[k], row_c[k], 1'b0, cy[k]);
    if (k < W - 1) begin : g_keep
      assign cy[k+1] = c;
    end else begin : g_drop
      logic unused_c;
      assign unused_c = c ^ cy[0];
    end
  end
endmodule

// File: rtl/rev_wallace_mul_chk.sv
module rev_wallace_mul_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic [2*N-1:0] prod,
  input logic [2*N-1:0] row_s,
  input logic [2*N-1:0] row_c
);
  localparam int W = 2 * N;

  logic [W-1:0] want;
  logic [W-1:0] rows_sum;
  assign want     = W'(a) * W'(b);
  assign rows_sum = row_s + row_c;

  always_comb begin
    a_r1_product: assert (prod == want);
    a_r1_two_rows: assert (rows_sum == want);
    if (a == '0 || b == '0) begin
      a_r2_zero: assert (prod == '0);
    end
    if (a == N'(1)) begin
      a_r3_unit_a: assert (prod == W'(b));
    end
    if (b == N'(1)) begin
      a_r3_unit_b: assert (prod == W'(a));
    end
    a_r8_low_bit: assert (prod[0] == (a[0] & b[0]));
  end
endmodule

bind rev_wallace_mul rev_wallace_mul_chk #(.N(N)) i_chk (
  .a(a), .b(b), .prod(prod), .row_s(row_s), .row_c(row_c)
);

// File: tb/test_rev_wallace_mul.sv
`timescale 1ns/1ps
module test_rev_wallace_mul;
  logic        clk = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [15:0] prod;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rev_wallace_mul #(.N(8)) i_rev_wallace_mul (.a(a), .b(b), .prod(prod));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y);
    @(posedge clk);
    #0.5;
    a = x;
    b = y;
    #1;
  endtask

  task automatic test_idle();
    apply(8'd0, 8'd0);
    check("R2 idle", prod, 16'd0);
  endtask

  task automatic test_zero();
    apply(8'd0, 8'd200);  check("R2", prod, 16'd0);
    apply(8'd255, 8'd0);  check("R2", prod, 16'd0);
  endtask

  task automatic test_unit();
    apply(8'd1, 8'd173);  check("R3", prod, 16'd173);
    apply(8'd255, 8'd1);  check("R3", prod, 16'd255);
    apply(8'd1, 8'd1);    check("R3", prod, 16'd1);
  endtask

  task automatic test_max();
    apply(8'hFF, 8'hFF);
    check("R4", prod, 16'hFE01);
  endtask

  task automatic test_pow2();
    for (int k = 0; k < 8; k++) begin
      apply(8'(1 << k), 8'hB7);
      check("R6", prod, 16'(16'hB7 << k));
      apply(8'hFF, 8'(1 << k));
      check("R6", prod, 16'(16'hFF << k));
    end
  endtask

  task automatic test_patterns();
    apply(8'hAA, 8'h55); check("R1", prod, 16'd14450);
    apply(8'h0F, 8'hF0); check("R1", prod, 16'd3600);
    apply(8'hFF, 8'h81); check("R1", prod, 16'd32895);
    apply(8'h80, 8'h80); check("R1", prod, 16'd16384);
  endtask

  task automatic test_swap();
    logic [15:0] first;
    for (int n = 0; n < 50; n++) begin
      logic [7:0] x;
      logic [7:0] y;
      x = 8'($urandom);
      y = 8'($urandom);
      apply(x, y);
      first = prod;
      apply(y, x);
      check("R7", prod, first);
    end
  endtask

  task automatic test_comb();
    @(posedge clk);
    #0.5;
    a = 8'd12; b = 8'd11;
    #0.5;
    check("R5", prod, 16'd132);
    a = 8'd13;
    #0.5;
    check("R5", prod, 16'd143);
  endtask

  task automatic test_lsb();
    apply(8'd13, 8'd7);  check("R8", {15'd0, prod[0]}, 16'd1);
    apply(8'd14, 8'd7);  check("R8", {15'd0, prod[0]}, 16'd0);
    apply(8'd255, 8'd3); check("R8", {15'd0, prod[0]}, 16'd1);
  endtask

  task automatic test_random();
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] x;
      logic [7:0] y;
      x = 8'($urandom);
      y = 8'($urandom);
      apply(x, y);
      check("R1", prod, 16'(x) * 16'(y));
    end
  endtask

  initial begin
    test_idle();
    test_zero();
    test_unit();
    test_max();
    test_pow2();
    test_patterns();
    test_swap();
    test_comb();
    test_lsb();
    test_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule